// File: doc/BRIEF.md
# UART Receive FIFO with Character Timeout

This block sits between a UART receive deserializer and the host-visible receive buffer register. Each byte the deserializer completes arrives as a one-cycle push strobe with its data and break flag. Each host read of the receive buffer arrives as a one-cycle pop strobe. The read data is shown combinationally on `rd_data` during the cycle of the read. The block keeps the data-ready and break-indicator status bits and an occupancy level, which the surrounding register logic compares against its trigger level.

When queueing is enabled, bytes sit in a 16-entry ring. The ring has a write pointer and a read pointer that wrap, and an occupancy count. A timer watches for data that has gone stale. It counts baud ticks supplied by the caller. Every accepted push restarts it, and so does every pop that leaves bytes behind. It raises a timeout-pending flag once four character times pass with no such activity while bytes remain. One character time, counted in baud ticks, is the number of data bits plus the number of stop bits, plus one when parity is on. With eight data bits, one stop bit and no parity this gives nine ticks, the usual reset setting.

When queueing is disabled, the block is a single holding register. A flush pulse empties the queue and cancels the timer. Any change of the enable flag also empties the queue.

Top module: `uart_rx_queue`

## Requirements
- R1: In queue mode, bytes leave in the order they were accepted. `rd_data` shows the oldest byte in the cycle of the pop that removes it.
- R2: A pop while the queue is empty returns 0x00 and leaves the level and the status bits unchanged.
- R3: `level` never exceeds 16. A push while the queue holds 16 bytes is discarded, and `overrun` is high for one cycle in the next cycle. A pop in the same cycle does not make room for that push.
- R4: In queue mode, an accepted push sets data-ready, and sets break-indicator when `push_brk` is 1. Both bits clear only when a pop, without a push in the same cycle, brings the level to zero. Data-ready equals "level is not zero".
- R5: The timer restarts on each accepted push and on each pop that leaves the level nonzero. After 4 × (character time) baud ticks with no restart, `timeout_pend` rises if bytes remain.
- R6: Any pop clears `timeout_pend` in the next cycle.
- R7: A flush sets the level and both pointers to zero, clears data-ready, break-indicator and `timeout_pend`, and stops the timer. A flush takes priority over a push or pop in the same cycle.
- R8: In holding mode, `level` stays 0. A push is accepted when data-ready is clear or a pop happens in the same cycle. An accepted push stores the byte and the break flag and sets data-ready. A pop clears data-ready and break-indicator. A push refused while data-ready is set leaves the held byte unchanged and pulses `overrun`.
- R9: The character time in baud ticks is (5 + `cfg_dbits`) + (`cfg_stop2` ? 2 : 1) + `cfg_par`, where `cfg_dbits` = 0..3 selects 5 to 8 data bits.
- R10: `can_accept` is high in queue mode while the level is below 16, and high in holding mode while data-ready is clear.
- R11: A change of `fifo_en` empties the queue, clears all status bits and switches the mode. The push or pop that arrives in that cycle is ignored.
- R12: After reset the block is in holding mode. Level, data-ready, break-indicator, `timeout_pend` and `overrun` are 0, `can_accept` is 1 and `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | 1 selects queue mode, 0 selects holding mode |
| flush | input | 1 | Empties the queue and cancels the timer |
| push | input | 1 | A received byte is offered |
| push_data | input | DW | Received byte |
| push_brk | input | 1 | Break flag that comes with the byte |
| pop | input | 1 | Host read of the receive buffer |
| baud_tick | input | 1 | One baud period elapsed |
| cfg_dbits | input | 2 | Data bits minus five |
| cfg_stop2 | input | 1 | Two stop bits |
| cfg_par | input | 1 | Parity bit present |
| rd_data | output | DW | Byte returned by a read |
| data_ready | output | 1 | Received data available |
| brk_flag | output | 1 | Break indicator |
| level | output | CW | Queue occupancy |
| timeout_pend | output | 1 | Character timeout pending |
| can_accept | output | 1 | A push would be accepted |
| overrun | output | 1 | One-cycle pulse when a push was dropped |

## Verification
The bench builds the block with its default values: a depth of 16, 8-bit data and a window of four characters. With a depth this small, random bursts of pushes reach the full queue and the overrun path within a few dozen cycles. With five data bits, one stop bit and no parity, the timeout window is only 24 ticks, so phases without reads run the timer to expiry many times. Random flushes and mode changes then interrupt a running timer.

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int DEPTH    = 16,
  parameter int DW       = 8,
  parameter int TO_CHARS = 4,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          push_brk,
  input  logic          pop,
  input  logic          baud_tick,
  input  logic [1:0]    cfg_dbits,
  input  logic          cfg_stop2,
  input  logic          cfg_par,
  output logic [DW-1:0] rd_data,
  output logic          data_ready,
  output logic          brk_flag,
  output logic [CW-1:0] level,
  output logic          timeout_pend,
  output logic          can_accept,
  output logic          overrun
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int TW = $clog2(TO_CHARS * 12 + 1) + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] hold;
  logic [PW-1:0] wptr, rptr;
  logic          mode_q, run;
  logic [TW-1:0] tcnt;

  wire clr       = flush | (fifo_en != mode_q);
  wire empty     = (level == '0);
  wire full      = (level == CW'(DEPTH));
  wire pop_ok    = mode_q & pop & ~empty;
  wire push_ok_q = mode_q & push & ~full;
  wire push_ok_h = ~mode_q & push & (~data_ready | pop);

  wire [CW-1:0] level_nx = level + CW'(push_ok_q) - CW'(pop_ok);
  wire          restart  = push_ok_q | (pop_ok & (level_nx != '0));

  wire [3:0]    cbits = 4'd5 + {2'b00, cfg_dbits} + (cfg_stop2 ? 4'd2 : 4'd1) + {3'b000, cfg_par};
  wire [TW-1:0] limit = TW'(TO_CHARS) * TW'(cbits);
  wire          expire = run & baud_tick & ~restart & ((tcnt + 1'b1) >= limit);

  function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign rd_data    = mode_q ? (empty ? '0 : mem[rptr]) : hold;
  assign can_accept = mode_q ? ~full : ~data_ready;

  always_ff @(posedge clk)
    if (!clr && push_ok_q) mem[wptr] <= push_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;  wptr <= '0;  rptr <= '0;  level <= '0;
      data_ready <= 1'b0;  brk_flag <= 1'b0;  timeout_pend <= 1'b0;
      run <= 1'b0;  tcnt <= '0;  hold <= '0;  overrun <= 1'b0;
    end else begin
      overrun <= ~clr & push & ~(push_ok_q | push_ok_h);
      if (clr) begin
        mode_q <= fifo_en;  wptr <= '0;  rptr <= '0;  level <= '0;
        data_ready <= 1'b0;  brk_flag <= 1'b0;  timeout_pend <= 1'b0;
        run <= 1'b0;  tcnt <= '0;
      end else if (mode_q) begin
        if (push_ok_q) wptr <= adv(wptr);
        if (pop_ok)    rptr <= adv(rptr);
        level <= level_nx;
        if (push_ok_q) begin
          data_ready <= 1'b1;
          if (push_brk) brk_flag <= 1'b1;
        end else if (pop_ok && level_nx == '0) begin
          data_ready <= 1'b0;
          brk_flag   <= 1'b0;
        end
        if (pop)                            timeout_pend <= 1'b0;
        else if (expire && level_nx != '0)  timeout_pend <= 1'b1;
        if (restart) begin
          run <= 1'b1;  tcnt <= '0;
        end else if (run && baud_tick) begin
          if (expire) begin run <= 1'b0; tcnt <= '0; end
          else        tcnt <= tcnt + 1'b1;
        end
      end else begin
        if (push_ok_h) begin
          hold <= push_data;  data_ready <= 1'b1;  brk_flag <= push_brk;
        end else if (pop) begin
          data_ready <= 1'b0;  brk_flag <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_queue_chk.sv
module uart_rx_queue_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          flush,
  input logic          push,
  input logic          pop,
  input logic          mode_q,
  input logic [CW-1:0] level,
  input logic          data_ready,
  input logic          timeout_pend,
  input logic          can_accept,
  input logic          overrun
);
  p_level_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));
  p_drop_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && push && !can_accept && !flush && fifo_en == mode_q) |=> overrun);
  p_ready_tracks_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> (data_ready == (level != '0)));
  p_pend_has_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pend |-> (level != '0));
  p_read_clears_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !timeout_pend);
  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0 && !timeout_pend && !data_ready));
  p_holding_no_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> (level == '0));
endmodule

bind uart_rx_queue uart_rx_queue_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .flush(flush), .push(push),
  .pop(pop), .mode_q(mode_q), .level(level), .data_ready(data_ready),
  .timeout_pend(timeout_pend), .can_accept(can_accept), .overrun(overrun)
);

// File: tb/uart_rx_queue_tb.sv
module uart_rx_queue_tb;
  localparam int DEPTH = 16, DW = 8, TO = 4, CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_en = 0, flush = 0, push = 0, push_brk = 0, pop = 0, baud_tick = 0;
  logic [DW-1:0] push_data = '0;
  logic [1:0] cfg_dbits = 2'd0;
  logic cfg_stop2 = 0, cfg_par = 0;
  logic [DW-1:0] rd_data;
  logic data_ready, brk_flag, timeout_pend, can_accept, overrun;
  logic [CW-1:0] level;

  always #2.5 clk = ~clk;

  uart_rx_queue #(.DEPTH(DEPTH), .DW(DW), .TO_CHARS(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .flush(flush), .push(push),
    .push_data(push_data), .push_brk(push_brk), .pop(pop), .baud_tick(baud_tick),
    .cfg_dbits(cfg_dbits), .cfg_stop2(cfg_stop2), .cfg_par(cfg_par),
    .rd_data(rd_data), .data_ready(data_ready), .brk_flag(brk_flag), .level(level),
    .timeout_pend(timeout_pend), .can_accept(can_accept), .overrun(overrun));

  int total = 0, bad = 0;
  bit done = 0;

  logic [DW-1:0] mq[$];
  logic [DW-1:0] m_hold = '0;
  bit m_mode = 0, m_dr = 0, m_brk = 0, m_pend = 0, m_run = 0, m_ovr = 0;
  int m_tcnt = 0;

  function automatic int win();
    return TO * (5 + int'(cfg_dbits) + (cfg_stop2 ? 2 : 1) + int'(cfg_par));
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int exp_rd;
    exp_rd = m_mode ? (mq.size() > 0 ? int'(mq[0]) : 0) : int'(m_hold);
    chk("R1", "rd_data", int'(rd_data), exp_rd);
    chk("R3", "level", int'(level), mq.size());
    chk("R3", "overrun", int'(overrun), int'(m_ovr));
    chk("R4", "data_ready", int'(data_ready), int'(m_dr));
    chk("R4", "brk_flag", int'(brk_flag), int'(m_brk));
    chk("R5", "timeout_pend", int'(timeout_pend), int'(m_pend));
    chk("R10", "can_accept", int'(can_accept), m_mode ? int'(mq.size() < DEPTH) : int'(!m_dr));
  endtask

  task automatic model_step(input bit ps, input logic [DW-1:0] pd, input bit pb,
                            input bit pp, input bit fl, input bit fe, input bit tk);
    int old_n, new_n;
    bit pok, qok, rs;
    old_n = mq.size();
    m_ovr = 0;
    if (fl || fe != m_mode) begin
      mq.delete(); m_dr = 0; m_brk = 0; m_pend = 0; m_run = 0; m_tcnt = 0; m_mode = fe;
    end else if (m_mode) begin
      qok = pp && old_n > 0;
      pok = ps && old_n < DEPTH;
      if (ps && !pok) m_ovr = 1;
      if (qok) void'(mq.pop_front());
      if (pok) mq.push_back(pd);
      new_n = mq.size();
      if (pok) begin m_dr = 1; if (pb) m_brk = 1; end
      else if (qok && new_n == 0) begin m_dr = 0; m_brk = 0; end
      rs = pok || (qok && new_n != 0);
      if (pp) m_pend = 0;
      if (rs) begin m_run = 1; m_tcnt = 0; end
      else if (m_run && tk) begin
        if (m_tcnt + 1 >= win()) begin
          m_run = 0; m_tcnt = 0;
          if (new_n != 0 && !pp) m_pend = 1;
        end else m_tcnt++;
      end
    end else begin
      if (ps && (!m_dr || pp)) begin m_hold = pd; m_dr = 1; m_brk = pb; end
      else begin
        if (ps) m_ovr = 1;
        if (pp) begin m_dr = 0; m_brk = 0; end
      end
    end
  endtask

  task automatic step(input bit ps, input logic [DW-1:0] pd, input bit pb,
                      input bit pp, input bit fl, input bit fe, input bit tk);
    push = ps; push_data = pd; push_brk = pb; pop = pp; flush = fl;
    fifo_en = fe; baud_tick = tk;
    model_step(ps, pd, pb, pp, fl, fe, tk);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    if (!done) begin
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'h1A2B3C);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    chk("R12", "level", int'(level), 0);
    chk("R12", "data_ready", int'(data_ready), 0);
    chk("R12", "can_accept", int'(can_accept), 1);
    chk("R12", "timeout_pend", int'(timeout_pend), 0);
    chk("R12", "rd_data", int'(rd_data), 0);
    chk("R12", "overrun", int'(overrun), 0);

    step(0, 0, 0, 0, 0, 1, 0);
    // R2: pop on empty queue
    push = 0; pop = 1;
    chk("R2", "rd_data on empty", int'(rd_data), 0);
    step(0, 0, 0, 1, 0, 1, 0);
    chk("R2", "level after empty pop", int'(level), 0);
    chk("R2", "data_ready after empty pop", int'(data_ready), 0);

    // R3: fill past the top
    for (int i = 0; i < DEPTH + 1; i++) step(1, 8'(8'h40 + i), 0, 0, 0, 1, 0);
    chk("R3", "overrun on full push", int'(overrun), 1);
    chk("R3", "level stays full", int'(level), DEPTH);
    chk("R10", "can_accept when full", int'(can_accept), 0);

    // R1: drain in order
    for (int i = 0; i < DEPTH; i++) begin
      chk("R1", "drain order", int'(rd_data), 8'h40 + i);
      step(0, 0, 0, 1, 0, 1, 0);
    end
    chk("R4", "data_ready after drain", int'(data_ready), 0);

    // R9 / R5: 5 data bits, 1 stop, no parity -> window 24 ticks
    cfg_dbits = 2'd0; cfg_stop2 = 0; cfg_par = 0;
    step(1, 8'h77, 1, 0, 0, 1, 1);
    chk("R4", "break set by push", int'(brk_flag), 1);
    for (int i = 0; i < 23; i++) step(0, 0, 0, 0, 0, 1, 1);
    chk("R9", "no timeout before window", int'(timeout_pend), 0);
    step(0, 0, 0, 0, 0, 1, 1);
    chk("R5", "timeout after window", int'(timeout_pend), 1);
    step(0, 0, 0, 1, 0, 1, 0);
    chk("R6", "read clears pending", int'(timeout_pend), 0);

    // R7: flush cancels timer
    step(1, 8'h11, 0, 0, 0, 1, 1);
    step(1, 8'h22, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 1, 1, 1);
    chk("R7", "level after flush", int'(level), 0);
    for (int i = 0; i < 30; i++) step(0, 0, 0, 0, 0, 1, 1);
    chk("R7", "no timeout after flush", int'(timeout_pend), 0);

    // R11: mode change empties
    for (int i = 0; i < 3; i++) step(1, 8'(i), 0, 0, 0, 1, 0);
    step(1, 8'h99, 0, 0, 0, 0, 0);
    chk("R11", "level after mode change", int'(level), 0);
    chk("R11", "data_ready after mode change", int'(data_ready), 0);

    // R8: holding register
    step(1, 8'hA5, 0, 0, 0, 0, 0);
    chk("R8", "held byte", int'(rd_data), 8'hA5);
    chk("R10", "can_accept while held", int'(can_accept), 0);
    step(1, 8'h5A, 0, 0, 0, 0, 0);
    chk("R8", "refused push keeps byte", int'(rd_data), 8'hA5);
    chk("R8", "refused push overrun", int'(overrun), 1);
    step(0, 0, 0, 1, 0, 0, 0);
    chk("R8", "read clears ready", int'(data_ready), 0);
    chk("R8", "level stays zero", int'(level), 0);

    // random phases
    for (int ph = 0; ph < 40; ph++) begin
      int pp_push, pp_pop, pp_tick, mode;
      pp_push = $urandom_range(0, 100);
      pp_pop  = $urandom_range(0, 100);
      pp_tick = $urandom_range(30, 100);
      mode    = ($urandom_range(0, 9) < 7) ? 1 : 0;
      cfg_dbits = 2'($urandom_range(0, 3));
      cfg_stop2 = 1'($urandom_range(0, 1));
      cfg_par   = 1'($urandom_range(0, 1));
      for (int c = 0; c < 150; c++) begin
        step(($urandom_range(0, 99) < pp_push), 8'($urandom),
             ($urandom_range(0, 15) == 0), ($urandom_range(0, 99) < pp_pop),
             ($urandom_range(0, 199) == 0), 1'(mode), ($urandom_range(0, 99) < pp_tick));
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule